// File: doc/BRIEF.md
# DS3 Loss-of-Signal Detector

This block watches the recovered serial bit stream of a DS3 receiver, one bit for each accepted beat, and keeps a loss-of-signal level. A loss of signal begins after a long unbroken run of spaces (zeros). It ends when enough marks (ones) have arrived within a sliding window of recent bit periods. So the rule that enters the alarm differs from the rule that leaves it. Besides the level, the block gives a pulse one clock wide whenever the level changes. Interrupt logic uses this pulse to set the loss-of-signal bit (bit 6) of its clear-on-read status register.

Bits arrive on a valid/ready stream. The detector takes a bit on every clock where `in_valid` is high. It never applies back-pressure: `in_ready` stays high, so a beat is accepted exactly when `in_valid` is high. A clock with `in_valid` low is not a bit period. On such a clock no counter, window or level moves, and `in_bit` is ignored. After reset the alarm is active, which matches the status reset value 0x40. The thresholds are parameters: run length 180, window length 180 and mark threshold 60.

Top module: `ds3_los_det`

## Requirements
- R1: While reset is held and on the first clock after it is released, `los` is 1 and `los_chg` is 0.
- R2: While `los` is 0, accepting the 180th consecutive zero sets `los` to 1 at that clock edge.
- R3: Any accepted one restarts the zero run. A run longer than 180 saturates and does not wrap, so it never declares a second time.
- R4: While `los` is 1, `los` clears at the edge that accepts the bit which brings the count of ones to 60. The count covers the last 180 accepted bits taken since the alarm began.
- R5: The exit count slides: a one accepted more than 180 accepted bits ago no longer counts toward the 60.
- R6: The exit history starts empty on reset and on every declaration. Ones received before the alarm began never count toward an exit.
- R7: `los_chg` is high for exactly one clock, on the clock after an edge where `los` toggled. At every other time it is 0.
- R8: A clock with `in_valid` low changes no state, whatever the value of `in_bit`.
- R9: `in_ready` is always 1 while out of reset. No beat is ever refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received bit is present this clock |
| in_bit | input | 1 | Received bit: 1 is a mark, 0 is a space |
| in_ready | output | 1 | Always 1; the stream is never stalled |
| los | output | 1 | Loss-of-signal level, 1 while the alarm is active |
| los_chg | output | 1 | One-clock pulse on each toggle of `los` |

## Verification
The assertions assume that `in_valid` and `in_bit` are stable around each rising edge. They also assume that a beat carries exactly one bit period, so every state change can be traced to a beat accepted on the edge before it. The stimulus drives both inputs on the falling edge only and spreads idle clocks through each phase. Some idle clocks carry a mark while the alarm is active, to show they are ignored. The bit patterns are chosen so that entry and exit thresholds are crossed by exactly one bit. They include zero runs broken one bit short, old ones sliding out of the window, and mark densities just below and just above the exit level.

// File: rtl/ds3_los_pkg.sv
package ds3_los_pkg;
  localparam int unsigned LOS_ZERO_RUN_DEF = 180;
  localparam int unsigned LOS_WIN_LEN_DEF  = 180;
  localparam int unsigned LOS_MARK_MIN_DEF = 60;

  typedef struct packed {
    logic valid;
    logic mark;
  } ds3_beat_t;
endpackage

// File: rtl/ds3_los_zero_run.sv
module ds3_los_zero_run
  import ds3_los_pkg::*;
#(
  parameter int unsigned ZERO_RUN = LOS_ZERO_RUN_DEF,
  localparam int unsigned RW = $clog2(ZERO_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ds3_beat_t     beat,
  output logic          run_hit,
  output logic [RW-1:0] run_cnt
);
  localparam logic [RW-1:0] RUN_MAX  = RW'(ZERO_RUN);
  localparam logic [RW-1:0] RUN_LAST = RW'(ZERO_RUN - 1);

  // the zero being accepted now completes the run
  assign run_hit = beat.valid && !beat.mark && (run_cnt >= RUN_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (beat.valid) begin
      if (beat.mark)              run_cnt <= '0;
      else if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ds3_los_mark_win.sv
module ds3_los_mark_win
  import ds3_los_pkg::*;
#(
  parameter int unsigned WIN_LEN  = LOS_WIN_LEN_DEF,
  parameter int unsigned MARK_MIN = LOS_MARK_MIN_DEF,
  localparam int unsigned CW = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  ds3_beat_t     beat,
  output logic          exit_hit,
  output logic [CW-1:0] ones_cnt
);
  logic [WIN_LEN-1:0] hist;
  logic               oldest;
  logic [CW-1:0]      ones_nxt;

  assign oldest   = hist[WIN_LEN-1];
  assign ones_nxt = ones_cnt + CW'(beat.mark) - CW'(oldest);
  assign exit_hit = beat.valid && (ones_nxt >= CW'(MARK_MIN));

  generate
    if (WIN_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n || clr)   hist <= '0;
        else if (beat.valid) hist <= beat.mark;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n || clr)   hist <= '0;
        else if (beat.valid) hist <= {hist[WIN_LEN-2:0], beat.mark};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   ones_cnt <= '0;
    else if (beat.valid) ones_cnt <= ones_nxt;
  end
endmodule

// File: rtl/ds3_los_ctrl.sv
module ds3_los_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic declare,
  input  logic recover,
  output logic los,
  output logic los_chg
);
  logic los_nxt;

  always_comb begin
    los_nxt = los;
    if (!los && declare)     los_nxt = 1'b1;
    else if (los && recover) los_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los     <= 1'b1;
      los_chg <= 1'b0;
    end else begin
      los     <= los_nxt;
      los_chg <= los_nxt ^ los;
    end
  end
endmodule

// File: rtl/ds3_los_det.sv
module ds3_los_det
  import ds3_los_pkg::*;
#(
  parameter int unsigned ZERO_RUN = LOS_ZERO_RUN_DEF,
  parameter int unsigned WIN_LEN  = LOS_WIN_LEN_DEF,
  parameter int unsigned MARK_MIN = LOS_MARK_MIN_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic los,
  output logic los_chg
);
  localparam int unsigned RW = $clog2(ZERO_RUN + 1);
  localparam int unsigned CW = $clog2(WIN_LEN + 1);

  ds3_beat_t     run_beat, win_beat;
  logic          run_hit, exit_hit, declare;
  logic [RW-1:0] zrun_q;
  logic [CW-1:0] marks_q;

  assign in_ready = 1'b1;
  assign run_beat = '{valid: in_valid, mark: in_bit};
  // exit window only advances during the alarm
  assign win_beat = '{valid: in_valid && los, mark: in_bit};
  assign declare  = run_hit && !los;

  ds3_los_zero_run #(.ZERO_RUN(ZERO_RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .beat(run_beat),
    .run_hit(run_hit), .run_cnt(zrun_q)
  );

  ds3_los_mark_win #(.WIN_LEN(WIN_LEN), .MARK_MIN(MARK_MIN)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(declare), .beat(win_beat),
    .exit_hit(exit_hit), .ones_cnt(marks_q)
  );

  ds3_los_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .declare(declare), .recover(exit_hit),
    .los(los), .los_chg(los_chg)
  );
endmodule

// File: rtl/ds3_los_chk.sv
module ds3_los_chk #(
  parameter int unsigned ZERO_RUN = 180,
  parameter int unsigned WIN_LEN  = 180,
  parameter int unsigned RW = 8,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_bit,
  input logic          in_ready,
  input logic          los,
  input logic          los_chg,
  input logic [RW-1:0] zrun,
  input logic [CW-1:0] marks
);
  AST_RESET_LOS: assert property (@(posedge clk) !rst_n |=> los && !los_chg); // R1
  AST_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> $past(in_valid && !in_bit)); // R2
  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= RW'(ZERO_RUN)); // R3
  AST_FALL_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(in_valid && in_bit)); // R4
  AST_MARKS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    marks <= CW'(WIN_LEN)); // R5
  AST_FRESH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> marks == '0); // R6
  AST_PULSE_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    los_chg |-> los != $past(los)); // R7
  AST_TOGGLE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (los != $past(los)) |-> los_chg); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(los) && $stable(zrun) && $stable(marks)); // R8
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready); // R9
endmodule

bind ds3_los_det ds3_los_chk #(
  .ZERO_RUN(ZERO_RUN), .WIN_LEN(WIN_LEN), .RW(RW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
  .in_ready(in_ready), .los(los), .los_chg(los_chg),
  .zrun(zrun_q), .marks(marks_q)
);

// File: tb/ds3_los_det_tb.sv
`timescale 1ns/1ps
module ds3_los_det_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready, los, los_chg;

  always #2.5 clk = ~clk;

  ds3_los_det u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .los(los), .los_chg(los_chg)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  bit    exp_los_q[$];
  bit    exp_chg_q[$];
  string tag_q[$];

  // reference state, built from the requirements
  int m_run = 0;
  bit m_los = 1'b1;
  bit m_hist[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit b, input string tag);
    bit prev;
    int ones;
    @(negedge clk);
    in_valid = v;
    in_bit   = b;
    prev = m_los;
    if (v) begin
      m_run = b ? 0 : ((m_run < 180) ? m_run + 1 : 180);
      if (!m_los) begin
        if (m_run >= 180) begin
          m_los = 1'b1;
          m_hist.delete();
        end
      end else begin
        m_hist.push_back(b);
        if (m_hist.size() > 180) void'(m_hist.pop_front());
        ones = 0;
        foreach (m_hist[i]) ones += int'(m_hist[i]);
        if (ones >= 60) m_los = 1'b0;
      end
    end
    exp_los_q.push_back(m_los);
    exp_chg_q.push_back(m_los != prev);
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expected item per clock once the driver has queued it
  always begin
    @(posedge clk);
    #1;
    if (exp_los_q.size() > 0) begin
      string t;
      t = tag_q.pop_front();
      chk(t, "los", int'(los), int'(exp_los_q.pop_front()));
      chk("R7", "los_chg", int'(los_chg), int'(exp_chg_q.pop_front()));
      chk("R9", "in_ready", int'(in_ready), 1);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "los in reset", int'(los), 1);
    chk("R1", "los_chg in reset", int'(los_chg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "los after reset", int'(los), 1);
    chk("R1", "los_chg after reset", int'(los_chg), 0);

    // exit from reset alarm: 59 marks hold, idle marks ignored, 60th clears
    for (int i = 0; i < 59; i++) step(1, 1, "R4");
    for (int i = 0; i < 5; i++)  step(0, 1, "R8");
    step(1, 1, "R4");
    for (int i = 0; i < 10; i++) step(0, 0, "R8");

    // a single mark one short of the run restarts it
    for (int i = 0; i < 179; i++) step(1, 0, "R3");
    step(1, 1, "R3");
    for (int i = 0; i < 179; i++) step(1, 0, "R3");
    for (int i = 0; i < 3; i++)   step(0, 0, "R8");
    step(1, 0, "R2");

    // history must start empty: earlier marks do not count
    step(1, 1, "R6");
    // sliding: first 30 marks age out before the count reaches 60
    for (int i = 0; i < 29; i++)  step(1, 1, "R5");
    for (int i = 0; i < 150; i++) step(1, 0, "R5");
    for (int i = 0; i < 30; i++)  step(1, 1, "R5");
    for (int i = 0; i < 30; i++)  step(1, 1, "R4");

    // re-enter, sparse marks stay in alarm, denser marks clear it
    for (int i = 0; i < 180; i++) step(1, 0, "R2");
    for (int i = 0; i < 400; i++) step(1, (i % 4) == 0, "R5");
    for (int i = 0; i < 200; i++) step(1, (i % 3) == 0, "R4");

    // long zero run: declares once and saturates
    for (int i = 0; i < 300; i++) step(1, 0, "R3");
    for (int i = 0; i < 60; i++)  step(1, 1, "R4");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "queue drained", exp_los_q.size(), 0);
    finish_run();
  end
endmodule